// File: doc/BRIEF.md
# Serial Flash Write-Enable Latch Front End

This block is the command front end of a serial NOR flash slave. It watches the chip-select, serial clock and serial data lines of an SPI bus and collects the bits of each frame. It also keeps the write-enable latch. A one-byte enable opcode sets the latch and a one-byte disable opcode clears it. Either one takes effect only when chip-select rises at the end of its frame.

Every command that changes the flash contents or its configuration is forwarded to a backend as a one-cycle request, together with its opcode. This is done only when three conditions hold: the latch is set, the frame is whole bytes long, and the backend is idle. When the backend reports that such an operation has finished, the latch clears by itself. The serial output is never driven by this block.

The bus pins are brought into the system clock through synchronizer chains. The system clock must run at least four times faster than the serial clock.

Top module: `flash_wel_front`

## Requirements
- R1: After reset `wel` is 0, `be_req` is 0 and `so_oe` is 0.
- R2: A frame of exactly 8 bits carrying 06h sets `wel` to 1. The change appears only after `cs_n` rises, never while `cs_n` is still low.
- R3: A frame of exactly 8 bits carrying 04h clears `wel` to 0.
- R4: A 06h or 04h frame whose bit count is not exactly 8 (for example 7, 9 or 16 bits) leaves `wel` unchanged.
- R5: A gated opcode is accepted when `wel` is 1, `be_busy` is 0, and the frame length is a nonzero multiple of 8 bits. The gated opcodes default to 02h, 32h, 20h, 40h, D8h, C7h, 01h and 42h, and only the first byte is decoded. On acceptance the block gives exactly one `be_req` pulse of one clock, with `be_cmd` equal to the opcode. `wel` stays 1 until the operation finishes.
- R6: A gated opcode received while `wel` is 0 produces no request.
- R7: While `be_busy` is 1, gated opcodes produce no request and leave `wel` unchanged. The 06h and 04h frames still take effect.
- R8: A one-cycle `be_done` pulse clears `wel`.
- R9: When `be_done` falls in the same cycle as the end of a 06h or 04h frame, the frame decides the final `wel` value.
- R10: Data on `si` is sampled on rising `sck` edges, most significant bit first. This works both with `sck` idling low and with `sck` idling high.
- R11: `so_oe` stays 0 at all times, so the serial output is never driven.
- R12: An opcode that is neither 06h, 04h nor gated causes no request and leaves `wel` unchanged.
- R13: A gated opcode in a frame whose bit count is not a multiple of 8 is discarded, with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | SPI serial data in |
| so | output | 1 | SPI serial data out (value unused) |
| so_oe | output | 1 | Output enable for so, always 0 |
| be_busy | input | 1 | Backend is executing an operation |
| be_done | input | 1 | One-cycle pulse: backend operation finished |
| be_req | output | 1 | One-cycle request to start a gated operation |
| be_cmd | output | 8 | Opcode belonging to be_req |
| wel | output | 1 | Write-enable latch |

## Verification
The backend completion pulse and the end of an enable frame can land in the same system clock cycle. One event sets the latch and the other clears it. The bench provokes this by raising `cs_n` and then timing `be_done` to the cycle in which the synchronized rising edge of `cs_n` is seen, which is two clock edges later. The reference model then expects the frame's value to survive. The same timing is used with a disable frame, where both events agree.

// File: rtl/flash_wel_pkg.sv
package flash_wel_pkg;

   typedef enum logic [1:0] {
      FR_NONE  = 2'd0,
      FR_WREN  = 2'd1,
      FR_WRDI  = 2'd2,
      FR_GATED = 2'd3
   } frame_kind_e;

   typedef struct packed {
      logic       end_pulse;
      logic       one_byte;
      logic       aligned;
      logic [7:0] opcode;
   } frame_info_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] d_sync
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
   import flash_wel_pkg::*;
#(
   parameter int OP_W = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_s,
   input  logic        sck_s,
   input  logic        si_s,
   output frame_info_t info
);
   localparam int IDX_W = $clog2(OP_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(OP_W - 1);

   logic              cs_prev, sck_prev;
   logic [OP_W-2:0]   shreg;
   logic [IDX_W-1:0]  bit_idx;
   logic [1:0]        nbytes;
   logic [OP_W-1:0]   opcode_q;
   logic              cs_rise, sck_rise;

   assign cs_rise  = cs_s & ~cs_prev;
   assign sck_rise = sck_s & ~sck_prev & ~cs_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev  <= 1'b1;
         sck_prev <= 1'b0;
         shreg    <= '0;
         bit_idx  <= '0;
         nbytes   <= '0;
         opcode_q <= '0;
      end else begin
         cs_prev  <= cs_s;
         sck_prev <= sck_s;
         if (cs_prev) begin
            bit_idx <= '0;
            nbytes  <= '0;
         end else if (sck_rise) begin
            shreg   <= {shreg[OP_W-3:0], si_s};
            bit_idx <= (bit_idx == LAST_IDX) ? '0 : bit_idx + 1'b1;
            if (bit_idx == LAST_IDX) begin
               if (nbytes != 2'd2) nbytes <= nbytes + 2'd1;
               if (nbytes == 2'd0) opcode_q <= {shreg, si_s};
            end
         end
      end
   end

   always_comb begin
      info.end_pulse = cs_rise;
      info.aligned   = (bit_idx == '0) && (nbytes != 2'd0);
      info.one_byte  = (bit_idx == '0) && (nbytes == 2'd1);
      info.opcode    = opcode_q;
   end

   // R4: after a full idle cycle of cs_n the byte counter must be empty
   p_idle_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_prev && cs_s) |=> (nbytes == 2'd0));
endmodule

// File: rtl/op_decode.sv
module op_decode
   import flash_wel_pkg::*;
#(
   parameter int                  N_GATED   = 8,
   parameter logic [N_GATED*8-1:0] GATED_OPS = 64'h02_32_20_40_D8_C7_01_42,
   parameter logic [7:0]          OP_SET    = 8'h06,
   parameter logic [7:0]          OP_CLR    = 8'h04
) (
   input  frame_info_t info,
   output frame_kind_e kind
);
   logic [N_GATED-1:0] hit;

   for (genvar i = 0; i < N_GATED; i++) begin : g_match
      localparam logic [7:0] OPI = GATED_OPS[i*8 +: 8];
      if (OPI == OP_SET || OPI == OP_CLR) begin : g_clash
         $error("gated opcode list collides with enable/disable opcode");
      end
      assign hit[i] = (info.opcode == OPI);
   end

   always_comb begin
      kind = FR_NONE;
      if (info.end_pulse) begin
         if (info.one_byte && info.opcode == OP_SET)      kind = FR_WREN;
         else if (info.one_byte && info.opcode == OP_CLR) kind = FR_WRDI;
         else if (info.aligned && (|hit))                 kind = FR_GATED;
      end
   end
endmodule

// File: rtl/wel_core.sv
module wel_core
   import flash_wel_pkg::*;
#(
   parameter bit FRAME_WINS = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  frame_kind_e kind,
   input  logic [7:0]  opcode,
   input  logic        be_busy,
   input  logic        be_done,
   output logic        wel,
   output logic        be_req,
   output logic [7:0]  be_cmd
);
   logic wel_q, wel_d, accept;

   assign accept = (kind == FR_GATED) && wel_q && !be_busy;

   if (FRAME_WINS) begin : g_frame_prio
      always_comb begin
         unique case (kind)
            FR_WREN: wel_d = 1'b1;
            FR_WRDI: wel_d = 1'b0;
            default: wel_d = be_done ? 1'b0 : wel_q;
         endcase
      end
   end else begin : g_done_prio
      always_comb begin
         if (be_done)              wel_d = 1'b0;
         else if (kind == FR_WREN) wel_d = 1'b1;
         else if (kind == FR_WRDI) wel_d = 1'b0;
         else                      wel_d = wel_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q  <= 1'b0;
         be_req <= 1'b0;
         be_cmd <= '0;
      end else begin
         wel_q  <= wel_d;
         be_req <= accept;
         if (accept) be_cmd <= opcode;
      end
   end

   assign wel = wel_q;

   p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      be_req |=> !be_req);
   p_req_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      be_req |-> $past(wel_q));
   p_no_req_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      be_req |-> !$past(be_busy));
   p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (be_done && !(FRAME_WINS && kind == FR_WREN)) |=> !wel_q);
   p_set_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel_q) |-> $past(kind == FR_WREN));
endmodule

// File: rtl/flash_wel_front.sv
module flash_wel_front
   import flash_wel_pkg::*;
#(
   parameter int                  SYNC_STAGES = 2,
   parameter int                  N_GATED     = 8,
   parameter logic [N_GATED*8-1:0] GATED_OPS   = 64'h02_32_20_40_D8_C7_01_42,
   parameter logic [7:0]          OP_SET      = 8'h06,
   parameter logic [7:0]          OP_CLR      = 8'h04,
   parameter bit                  FRAME_WINS  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       si,
   output logic       so,
   output logic       so_oe,
   input  logic       be_busy,
   input  logic       be_done,
   output logic       be_req,
   output logic [7:0] be_cmd,
   output logic       wel
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (N_GATED < 1) begin : g_bad_list
      $error("N_GATED must be at least 1");
   end
   if (OP_SET == OP_CLR) begin : g_bad_ops
      $error("enable and disable opcodes must differ");
   end

   logic [2:0]  pins_s;
   frame_info_t info;
   frame_kind_e kind;

   spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({cs_n, sck, si}),
      .d_sync  (pins_s)
   );

   spi_frame_rx #(.OP_W(8)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_s  (pins_s[2]),
      .sck_s (pins_s[1]),
      .si_s  (pins_s[0]),
      .info  (info)
   );

   op_decode #(
      .N_GATED(N_GATED), .GATED_OPS(GATED_OPS), .OP_SET(OP_SET), .OP_CLR(OP_CLR)
   ) u_dec (
      .info (info),
      .kind (kind)
   );

   wel_core #(.FRAME_WINS(FRAME_WINS)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .kind    (kind),
      .opcode  (info.opcode),
      .be_busy (be_busy),
      .be_done (be_done),
      .wel     (wel),
      .be_req  (be_req),
      .be_cmd  (be_cmd)
   );

   assign so    = 1'b0;
   assign so_oe = 1'b0;
endmodule

// File: tb/sim_flash_wel_front.sv
module sim_flash_wel_front;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0;
   logic       be_busy = 1'b0, be_done = 1'b0;
   logic       so, so_oe, be_req, wel;
   logic [7:0] be_cmd;

   int total = 0, bad = 0;
   int req_seen = 0, req_dbl = 0, oe_hits = 0;
   logic [7:0] last_cmd = 8'h00;
   logic       prev_req = 1'b0;

   // reference model state
   logic       m_wel = 1'b0;
   int         m_req = 0;
   logic [7:0] m_cmd = 8'h00;

   always #4 clk = ~clk;   // 125 MHz

   flash_wel_front u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .so(so), .so_oe(so_oe), .be_busy(be_busy), .be_done(be_done),
      .be_req(be_req), .be_cmd(be_cmd), .wel(wel)
   );

   // per-clock observation of outputs
   always @(negedge clk) if (rst_n) begin
      if (so_oe !== 1'b0) oe_hits++;
      if (be_req === 1'b1) begin
         req_seen++;
         last_cmd = be_cmd;
         if (prev_req) req_dbl++;
      end
      prev_req = be_req;
   end

   function automatic bit is_gated(input logic [7:0] op);
      logic [7:0] lst [8] = '{8'h02, 8'h32, 8'h20, 8'h40, 8'hD8, 8'hC7, 8'h01, 8'h42};
      foreach (lst[i]) if (lst[i] == op) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic f_begin(input bit m3);
      @(negedge clk);
      sck = m3;
      clks(2);
      cs_n = 1'b0;
      clks(4);
   endtask

   task automatic f_bits(input logic [31:0] data, input int n, input bit m3);
      for (int i = n - 1; i >= 0; i--) begin
         if (m3) sck = 1'b0;
         si = data[i];
         clks(4);
         sck = 1'b1;
         clks(4);
         if (!m3) sck = 1'b0;
      end
   endtask

   task automatic f_end(input bit with_done);
      clks(2);
      cs_n = 1'b1;
      if (with_done) begin
         repeat (2) @(posedge clk);
         @(negedge clk);
         be_done = 1'b1;
         @(negedge clk);
         be_done = 1'b0;
      end
      clks(8);
   endtask

   // model update for one frame
   task automatic model(input logic [31:0] data, input int n, input bit done_too);
      logic [7:0] op;
      op = (n >= 8) ? 8'(data >> (n - 8)) : 8'h00;
      if (n == 8 && op == 8'h06)      m_wel = 1'b1;
      else if (n == 8 && op == 8'h04) m_wel = 1'b0;
      else begin
         if (n > 0 && n % 8 == 0 && is_gated(op) && m_wel && !be_busy) begin
            m_req++;
            m_cmd = op;
         end
         if (done_too) m_wel = 1'b0;
      end
   endtask

   task automatic frame(input logic [31:0] data, input int n, input bit m3, input bit done_too);
      model(data, n, done_too);
      f_begin(m3);
      f_bits(data, n, m3);
      f_end(done_too);
   endtask

   task automatic done_pulse();
      @(negedge clk) be_done = 1'b1;
      @(negedge clk) be_done = 1'b0;
      m_wel = 1'b0;
      clks(2);
   endtask

   task automatic compare(input string req);
      chk({req, " wel"}, 32'(wel), 32'(m_wel));
      chk({req, " reqs"}, 32'(req_seen), 32'(m_req));
      chk({req, " cmd"}, 32'(last_cmd), 32'(m_cmd));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      clks(3);
      chk("R1 wel", 32'(wel), 0);
      chk("R1 be_req", 32'(be_req), 0);
      chk("R1 so_oe", 32'(so_oe), 0);
      rst_n = 1'b1;
      clks(4);
      chk("R1 wel after release", 32'(wel), 0);

      // R2: no change while cs_n low, then set on rising cs_n
      model(32'h06, 8, 1'b0);
      f_begin(1'b0);
      f_bits(32'h06, 8, 1'b0);
      clks(10);
      chk("R2 wel before cs_n rise", 32'(wel), 0);
      f_end(1'b0);
      compare("R2");

      frame(32'h04, 8, 1'b1, 1'b0);   compare("R3 R10 mode3 disable");
      frame(32'h06, 8, 1'b1, 1'b0);   compare("R10 mode3 enable");
      frame(32'h04, 8, 1'b0, 1'b0);   compare("R3 mode0 disable");

      frame(32'h03, 7, 1'b0, 1'b0);   compare("R4 7 bits");
      frame(32'h0C, 9, 1'b0, 1'b0);   compare("R4 9 bits");
      frame(32'h0606, 16, 1'b1, 1'b0); compare("R4 16 bits");

      frame(32'h02_000000, 32, 1'b0, 1'b0); compare("R6 gated without wel");

      frame(32'h06, 8, 1'b0, 1'b0);
      frame(32'h02_123456, 32, 1'b0, 1'b0); compare("R5 page program");
      done_pulse();                          compare("R8 done clears");

      frame(32'h06, 8, 1'b0, 1'b0);
      be_busy = 1'b1;
      frame(32'hD8_010000, 32, 1'b1, 1'b0); compare("R7 busy rejects");
      frame(32'h04, 8, 1'b0, 1'b0);         compare("R7 disable while busy");
      frame(32'h06, 8, 1'b1, 1'b0);         compare("R7 enable while busy");
      be_busy = 1'b0;

      frame(32'hC7, 8, 1'b1, 1'b0);         compare("R5 R10 one-byte gated mode3");
      done_pulse();
      frame(32'h06, 8, 1'b0, 1'b0);
      frame(32'h0400, 13, 1'b0, 1'b0);      compare("R13 misaligned gated");
      frame(32'h9F, 8, 1'b0, 1'b0);         compare("R12 unknown 8 bits");
      frame(32'hAB_000000, 32, 1'b1, 1'b0); compare("R12 unknown 32 bits");
      frame(32'h42_00FF, 24, 1'b1, 1'b0);   compare("R5 otp program");

      // R9: completion pulse lands on the frame-end cycle
      frame(32'h04, 8, 1'b0, 1'b0);
      frame(32'h06, 8, 1'b0, 1'b1);         compare("R9 enable beats done");
      frame(32'h04, 8, 1'b1, 1'b1);         compare("R9 disable with done");

      chk("R5 single-cycle request", 32'(req_dbl), 0);
      chk("R11 so_oe never high", 32'(oe_hits), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule